// File: doc/BRIEF.md
# Phit-to-Flit Link Assembler

This block sits on the receive side of a wide, fast link whose clock runs at exactly five times the switch core clock. Each cycle of the link clock may deliver one 14-bit phit. The assembler packs every run of five phits into one 70-bit flit and hands that flit to the core clock domain. The core therefore receives at most one flit per core cycle, which matches the rate at which the link can supply them. The upper 6 bits of each flit are control and the lower 64 bits are data.

A separate framing wire marks the first phit of every flit. The assembler aligns itself on that wire. It discards traffic until it is aligned, and it restarts assembly if a new frame begins before the current one is complete.

In the core domain the block also follows request packets. Each packet is built from flits and is either a one-word or an eight-word read/write request. The control field of the first flit declares the length, and a control bit marks the final flit. When a packet ends, the block reports whether the number of flits matched the declared length.

Top module: `pfa_link_assembler`

## Requirements
- R1: After reset, flit_vld, pkt_end, pkt_len_err and marker_err are low, and flit_data and flit_ctrl are zero.
- R2: Phits arriving while unaligned (after reset, or when the phit due as first of a flit lacks phit_start) are discarded; such a phit drops alignment and no flit results until a phit with phit_start is accepted.
- R3: The phit accepted with phit_start becomes bits 69:56 of the flit and each following phit fills the next 14 bits down; flit_ctrl is flit bits 69:64 and flit_data is bits 63:0.
- R4: With phits arriving back to back, every completed flit is presented exactly once, in arrival order, with flit_vld high for one core cycle, within one core cycle of its fifth phit.
- R5: While flit_vld is low, flit_data and flit_ctrl keep the value of the most recent flit.
- R6: Cycles with phit_vld low are ignored by assembly; a flit whose phits are separated by idle cycles is assembled the same as a contiguous one.
- R7: A phit_start accepted in the middle of a flit pulses marker_err for one link cycle on the next link edge, drops the partial flit and starts a new flit with that phit.
- R8: pkt_end is high together with flit_vld exactly for a flit whose flit_ctrl bit 5 (last flit of packet) is set.
- R9: At pkt_end, pkt_len_err is set unless the packet had exactly 1 flit with flit_ctrl bit 4 of its first flit clear (one-word), or exactly 8 flits with that bit set (eight-word); bit 4 of later flits is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_link | input | 1 | Link clock, five times the core clock and edge-aligned with it |
| clk_core | input | 1 | Switch core clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| phit_vld | input | 1 | A phit is present this link cycle |
| phit_start | input | 1 | Framing wire: this phit is the first of a flit |
| phit | input | 14 | Phit data |
| marker_err | output | 1 | Link domain: framing mark seen in the middle of a flit |
| flit_vld | output | 1 | Core domain: a new flit is presented |
| flit_data | output | 64 | Flit data bits |
| flit_ctrl | output | 6 | Flit control bits (bit 5 last, bit 4 eight-word, 3:0 passed through) |
| pkt_end | output | 1 | Core domain: the presented flit closes a packet |
| pkt_len_err | output | 1 | Core domain: the closed packet had a wrong length |

## Verification
A table of packets is streamed with phits back to back. It contains a well-formed one-word read, a well-formed eight-word write, a one-word packet that claims the long length, and a two-flit packet. These cases separate correct bit placement and full-rate delivery from errors in length accounting. A seven-flit long packet checks that a count just short of eight is still caught. Separate runs send unframed phits after reset, a missing mark at a flit boundary, a mark that arrives mid-flit, and a flit whose phits are spread by idle cycles. These runs show whether alignment is gained, lost and regained on the framing wire alone, and whether stalls are tolerated.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

    localparam int unsigned PHIT_W_DEF    = 14;
    localparam int unsigned PHITS_DEF     = 5;
    localparam int unsigned CTRL_W_DEF    = 6;
    localparam int unsigned LONG_LEN_DEF  = 8;
    localparam int unsigned SHORT_LEN_DEF = 1;

    // Positions inside the control field
    localparam int unsigned CTRL_LAST_BIT = 5;
    localparam int unsigned CTRL_LONG_BIT = 4;

    typedef enum logic {
        GATHER_HUNT = 1'b0,
        GATHER_RUN  = 1'b1
    } gather_state_e;

endpackage

// File: rtl/pfa_phit_gather.sv
// Link-domain side: aligns on the framing wire, shifts phits in
// most-significant first and parks each finished flit in a hold
// register, flipping a toggle to announce it.
module pfa_phit_gather
    import pfa_pkg::*;
#(
    parameter int unsigned PHIT_W = PHIT_W_DEF,
    parameter int unsigned PHITS  = PHITS_DEF
) (
    input  logic                      clk_link,
    input  logic                      rst_n,
    input  logic                      phit_vld,
    input  logic                      phit_start,
    input  logic [PHIT_W-1:0]         phit,
    output logic [PHIT_W*PHITS-1:0]   hold_o,
    output logic                      tog_o,
    output logic                      merr_o
);

    localparam int unsigned FLIT_W = PHIT_W * PHITS;
    localparam int unsigned PART_W = FLIT_W - PHIT_W;
    localparam int unsigned CNT_W  = (PHITS > 2) ? $clog2(PHITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHITS - 1);

    typedef struct packed {
        gather_state_e      st;
        logic [CNT_W-1:0]   cnt;
        logic [PART_W-1:0]  part;
        logic [FLIT_W-1:0]  hold;
        logic               tog;
        logic               merr;
    } gather_t;

    gather_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.merr = 1'b0;
        if (phit_vld) begin
            if (phit_start) begin
                // mark in the middle of a flit: drop the partial one
                r_d.merr = (r_q.st == GATHER_RUN) && (r_q.cnt != '0);
                r_d.st   = GATHER_RUN;
                r_d.part = PART_W'(phit);
                r_d.cnt  = CNT_W'(1);
            end else if (r_q.st == GATHER_RUN) begin
                if (r_q.cnt == '0) begin
                    // first phit of a flit without its mark
                    r_d.st = GATHER_HUNT;
                end else if (r_q.cnt == CNT_LAST) begin
                    r_d.hold = {r_q.part, phit};
                    r_d.tog  = ~r_q.tog;
                    r_d.cnt  = '0;
                end else begin
                    r_d.part = PART_W'({r_q.part, phit});
                    r_d.cnt  = r_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_link) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_o = r_q.hold;
    assign tog_o  = r_q.tog;
    assign merr_o = r_q.merr;

endmodule

// File: rtl/pfa_flit_capture.sv
// Core-domain side: a change of the toggle means the hold register
// carries a flit not yet taken. The clocks are edge-aligned at 5:1,
// so the hold register is stable across every core sampling edge.
module pfa_flit_capture #(
    parameter int unsigned FLIT_W = 70
) (
    input  logic               clk_core,
    input  logic               rst_n,
    input  logic [FLIT_W-1:0]  hold_i,
    input  logic               tog_i,
    output logic               cap_o,
    output logic               vld_o,
    output logic [FLIT_W-1:0]  flit_o
);

    typedef struct packed {
        logic               seen;
        logic               vld;
        logic [FLIT_W-1:0]  flit;
    } cap_t;

    cap_t r_q, r_d;
    logic cap;

    always_comb begin
        cap     = (tog_i != r_q.seen);
        r_d     = r_q;
        r_d.vld = cap;
        if (cap) begin
            r_d.seen = tog_i;
            r_d.flit = hold_i;
        end
    end

    always_ff @(posedge clk_core) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cap_o  = cap;
    assign vld_o  = r_q.vld;
    assign flit_o = r_q.flit;

endmodule

// File: rtl/pfa_pkt_check.sv
// Core-domain packet tracker: counts flits up to the one carrying the
// last mark and compares the count with the length the first flit declared.
module pfa_pkt_check
    import pfa_pkg::*;
#(
    parameter int unsigned CTRL_W    = CTRL_W_DEF,
    parameter int unsigned LONG_LEN  = LONG_LEN_DEF,
    parameter int unsigned SHORT_LEN = SHORT_LEN_DEF,
    parameter int unsigned LAST_BIT  = CTRL_LAST_BIT,
    parameter int unsigned LONG_BIT  = CTRL_LONG_BIT
) (
    input  logic              clk_core,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              end_o,
    output logic              err_o
);

    localparam int unsigned CNT_W   = $clog2(LONG_LEN + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] N_LONG  = CNT_W'(LONG_LEN);
    localparam logic [CNT_W-1:0] N_SHORT = CNT_W'(SHORT_LEN);

    typedef struct packed {
        logic              busy;
        logic              decl_long;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        logic              perr;
    } pkt_t;

    pkt_t r_q, r_d;
    logic [CNT_W-1:0] n_cnt;
    logic             decl;

    always_comb begin
        r_d      = r_q;
        r_d.pend = 1'b0;
        r_d.perr = 1'b0;
        if (!r_q.busy) begin
            n_cnt = CNT_W'(1);
            decl  = ctrl_i[LONG_BIT];
        end else begin
            n_cnt = (r_q.cnt == CNT_MAX) ? CNT_MAX : r_q.cnt + 1'b1;
            decl  = r_q.decl_long;
        end
        if (cap_i) begin
            if (ctrl_i[LAST_BIT]) begin
                r_d.pend      = 1'b1;
                r_d.perr      = decl ? (n_cnt != N_LONG) : (n_cnt != N_SHORT);
                r_d.busy      = 1'b0;
                r_d.decl_long = 1'b0;
                r_d.cnt       = '0;
            end else begin
                r_d.busy      = 1'b1;
                r_d.decl_long = decl;
                r_d.cnt       = n_cnt;
            end
        end
    end

    always_ff @(posedge clk_core) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign end_o = r_q.pend;
    assign err_o = r_q.perr;

endmodule

// File: rtl/pfa_link_assembler.sv
module pfa_link_assembler
    import pfa_pkg::*;
#(
    parameter int unsigned PHIT_W    = PHIT_W_DEF,
    parameter int unsigned PHITS     = PHITS_DEF,
    parameter int unsigned CTRL_W    = CTRL_W_DEF,
    parameter int unsigned LONG_LEN  = LONG_LEN_DEF,
    parameter int unsigned SHORT_LEN = SHORT_LEN_DEF
) (
    input  logic                             clk_link,
    input  logic                             clk_core,
    input  logic                             rst_n,
    input  logic                             phit_vld,
    input  logic                             phit_start,
    input  logic [PHIT_W-1:0]                phit,
    output logic                             marker_err,
    output logic                             flit_vld,
    output logic [PHIT_W*PHITS-CTRL_W-1:0]   flit_data,
    output logic [CTRL_W-1:0]                flit_ctrl,
    output logic                             pkt_end,
    output logic                             pkt_len_err
);

    localparam int unsigned FLIT_W = PHIT_W * PHITS;
    localparam int unsigned DATA_W = FLIT_W - CTRL_W;

    logic [FLIT_W-1:0] hold;
    logic              tog;
    logic              cap;
    logic [FLIT_W-1:0] flit;

    pfa_phit_gather #(
        .PHIT_W (PHIT_W),
        .PHITS  (PHITS)
    ) i_gather (
        .clk_link   (clk_link),
        .rst_n      (rst_n),
        .phit_vld   (phit_vld),
        .phit_start (phit_start),
        .phit       (phit),
        .hold_o     (hold),
        .tog_o      (tog),
        .merr_o     (marker_err)
    );

    pfa_flit_capture #(
        .FLIT_W (FLIT_W)
    ) i_capture (
        .clk_core (clk_core),
        .rst_n    (rst_n),
        .hold_i   (hold),
        .tog_i    (tog),
        .cap_o    (cap),
        .vld_o    (flit_vld),
        .flit_o   (flit)
    );

    pfa_pkt_check #(
        .CTRL_W    (CTRL_W),
        .LONG_LEN  (LONG_LEN),
        .SHORT_LEN (SHORT_LEN),
        .LAST_BIT  (CTRL_LAST_BIT),
        .LONG_BIT  (CTRL_LONG_BIT)
    ) i_pkt (
        .clk_core (clk_core),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .ctrl_i   (hold[FLIT_W-1 -: CTRL_W]),
        .end_o    (pkt_end),
        .err_o    (pkt_len_err)
    );

    assign flit_ctrl = flit[FLIT_W-1 -: CTRL_W];
    assign flit_data = flit[DATA_W-1:0];

endmodule

// File: rtl/pfa_link_assembler_chk.sv
module pfa_link_assembler_chk #(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned CTRL_W   = 6,
    parameter int unsigned LAST_BIT = 5
) (
    input logic              clk_link,
    input logic              clk_core,
    input logic              rst_n,
    input logic              phit_vld,
    input logic              phit_start,
    input logic              marker_err,
    input logic              flit_vld,
    input logic [DATA_W-1:0] flit_data,
    input logic [CTRL_W-1:0] flit_ctrl,
    input logic              pkt_end,
    input logic              pkt_len_err
);

    assert_flit_held_R5: assert property (@(posedge clk_core) disable iff (!rst_n)
        !flit_vld |-> ($stable(flit_data) && $stable(flit_ctrl)));

    assert_mark_caused_R7: assert property (@(posedge clk_link) disable iff (!rst_n)
        marker_err |-> $past(phit_vld && phit_start));

    assert_end_on_last_R8: assert property (@(posedge clk_core) disable iff (!rst_n)
        pkt_end |-> (flit_vld && flit_ctrl[LAST_BIT]));

    assert_err_at_end_R9: assert property (@(posedge clk_core) disable iff (!rst_n)
        pkt_len_err |-> pkt_end);

endmodule

bind pfa_link_assembler pfa_link_assembler_chk #(
    .DATA_W   (DATA_W),
    .CTRL_W   (CTRL_W),
    .LAST_BIT (pfa_pkg::CTRL_LAST_BIT)
) i_chk (
    .clk_link    (clk_link),
    .clk_core    (clk_core),
    .rst_n       (rst_n),
    .phit_vld    (phit_vld),
    .phit_start  (phit_start),
    .marker_err  (marker_err),
    .flit_vld    (flit_vld),
    .flit_data   (flit_data),
    .flit_ctrl   (flit_ctrl),
    .pkt_end     (pkt_end),
    .pkt_len_err (pkt_len_err)
);

// File: tb/test_pfa_link_assembler.sv
module test_pfa_link_assembler;

    localparam int PW = 14;
    localparam int NP = 5;
    localparam int CW = 6;
    localparam int FW = PW * NP;
    localparam int DW = FW - CW;

    // [15:10] ctrl, [9:2] data seed, [1] expected end, [0] expected length error
    localparam logic [15:0] VECS [0:11] = '{
        {6'b100001, 8'h11, 2'b10},   // one-word read, fine
        {6'b011010, 8'h20, 2'b00},   // eight-word write, first flit
        {6'b001010, 8'h21, 2'b00},
        {6'b000010, 8'h22, 2'b00},   // long bit dropped on a later flit
        {6'b001010, 8'h23, 2'b00},
        {6'b001010, 8'h24, 2'b00},
        {6'b001010, 8'h25, 2'b00},
        {6'b001010, 8'h26, 2'b00},
        {6'b101010, 8'h27, 2'b10},   // eighth flit closes it
        {6'b110011, 8'h30, 2'b11},   // single flit claiming long length
        {6'b000100, 8'h40, 2'b00},   // two flits, short declared
        {6'b100100, 8'h41, 2'b11}
    };

    logic clk_link = 1'b0;
    logic clk_core = 1'b0;
    logic rst_n = 1'b0;
    logic phit_vld = 1'b0;
    logic phit_start = 1'b0;
    logic [PW-1:0] phit = '0;
    logic marker_err, flit_vld, pkt_end, pkt_len_err;
    logic [DW-1:0] flit_data;
    logic [CW-1:0] flit_ctrl;

    int checks = 0;
    int errors = 0;
    int exp_n = 0, got_n = 0, chk_idx = 0, mk_cnt = 0;
    logic [FW+1:0] exp_q [0:63];
    logic [FW+1:0] got_q [0:63];

    pfa_link_assembler i_pfa_link_assembler (
        .clk_link    (clk_link),
        .clk_core    (clk_core),
        .rst_n       (rst_n),
        .phit_vld    (phit_vld),
        .phit_start  (phit_start),
        .phit        (phit),
        .marker_err  (marker_err),
        .flit_vld    (flit_vld),
        .flit_data   (flit_data),
        .flit_ctrl   (flit_ctrl),
        .pkt_end     (pkt_end),
        .pkt_len_err (pkt_len_err)
    );

    // 100 MHz link clock, core clock at one fifth, rising edges aligned
    initial forever #5 clk_link = ~clk_link;
    initial forever #25 clk_core = ~clk_core;

    always @(negedge clk_core) begin
        if (rst_n && flit_vld && got_n < 64) begin
            got_q[got_n] = {flit_ctrl, flit_data, pkt_end, pkt_len_err};
            got_n++;
        end
    end

    always @(negedge clk_link) begin
        if (rst_n && marker_err) mk_cnt++;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [FW+1:0] act, input logic [FW+1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_phit(input bit st, input logic [PW-1:0] p);
        @(negedge clk_link);
        phit_vld   = 1'b1;
        phit_start = st;
        phit       = p;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk_link);
            phit_vld   = 1'b0;
            phit_start = 1'b0;
        end
    endtask

    task automatic send_flit(input logic [CW-1:0] c, input logic [DW-1:0] d,
                             input bit e, input bit er, input int gap);
        logic [FW-1:0] w;
        w = {c, d};
        for (int i = 0; i < NP; i++) begin
            if (gap > 0 && i > 0) idle(gap);
            send_phit(i == 0, w[FW-1-PW*i -: PW]);
        end
        exp_q[exp_n] = {c, d, e, er};
        exp_n++;
    endtask

    task automatic compare(input string tag);
        int lim;
        idle(1);
        repeat (3) @(negedge clk_core);
        check(got_n == exp_n, {tag, " flit count"}, got_n, exp_n);
        lim = (got_n < exp_n) ? got_n : exp_n;
        for (int i = chk_idx; i < lim; i++) begin
            check(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
        end
        chk_idx = exp_n;
        got_n   = exp_n;
    endtask

    initial begin
        repeat (4) @(negedge clk_core);
        @(negedge clk_link);
        rst_n = 1'b1;
        @(negedge clk_core);

        // R1: quiet outputs after reset
        check(!flit_vld && !pkt_end && !pkt_len_err && !marker_err,
              "R1 flags after reset", {flit_vld, pkt_end, pkt_len_err, marker_err}, 0);
        check(flit_data == '0 && flit_ctrl == '0, "R1 flit after reset",
              {flit_ctrl, flit_data}, 0);

        // R2: unframed phits after reset are dropped
        for (int i = 0; i < 7; i++) send_phit(1'b0, PW'(14'h1000 + i));
        compare("R2 unaligned after reset");

        // R3 R4 R8 R9: table streamed back to back
        for (int i = 0; i < 12; i++) begin
            logic [7:0] s;
            s = VECS[i][9:2];
            send_flit(VECS[i][15:10], {4{s, ~s}}, VECS[i][1], VECS[i][0], 0);
        end
        compare("R3 R4 R8 R9 table");
        check(mk_cnt == 0, "R7 no stray mark error", mk_cnt, 0);

        // R5: output held while idle
        repeat (3) @(negedge clk_core);
        check(!flit_vld && {flit_ctrl, flit_data} == exp_q[exp_n-1][FW+1:2],
              "R5 hold", {flit_vld, flit_ctrl, flit_data}, {1'b0, exp_q[exp_n-1][FW+1:2]});

        // R7: mark arrives mid-flit, partial one dropped
        send_phit(1'b1, 14'h3FFF);
        send_phit(1'b0, 14'h1234);
        send_flit(6'b100101, 64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0, 0);
        compare("R7 resync flit");
        check(mk_cnt == 1, "R7 mark error pulse count", mk_cnt, 1);

        // R2: first phit of a flit missing its mark loses alignment
        for (int i = 0; i < NP; i++) send_phit(1'b0, PW'(14'h2A00 + i));
        send_flit(6'b100000, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 0);
        compare("R2 lost mark");
        check(mk_cnt == 1, "R2 no mark error when hunting", mk_cnt, 1);

        // R6: idle cycles between phits
        send_flit(6'b100110, 64'hF0E1_D2C3_B4A5_9687, 1'b1, 1'b0, 2);
        compare("R6 gapped phits");

        // R9: long declared, closed after seven flits
        for (int i = 0; i < 7; i++) begin
            send_flit((i == 0) ? 6'b011000 : ((i == 6) ? 6'b101000 : 6'b001000),
                      {8{8'(8'h50 + i)}}, i == 6, i == 6, 0);
        end
        compare("R9 seven-flit long packet");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule